// File: doc/BRIEF.md
# Snapshot-Read Wide Register

This block is one 64-bit register slice that a 32-bit CPU read port reaches through two consecutive word addresses. Hardware drives the live field values continuously. A snapshot buffer lets software read all 64 bits as one coherent value, even though the read is split across two accesses.

A trigger event copies every field into the buffer in a single clock edge. A parameter chooses the trigger source:
- **Self:** a read of the register's own low sub-word. That read returns the live low word and latches the remainder in the same edge, so both halves come from one instant.
- **Other register:** a read of one other register address. Several slices can share that address and latch together.
- **External:** a single-bit input whose active level is set by a parameter.

Buffered sub-word reads return the stored snapshot. A group of per-field strobes marks the cycles in which the fields are actually sampled.

Top module: `snap_rdreg`

## Requirements
- R1: After synchronous reset, `rd_data` is zero, `rd_strobe` is zero and the snapshot buffer holds zero. A buffered read issued before any trigger returns zero.
- R2: `rd_data` is registered. It shows the result of a read one clock after the edge that samples `rd_en`. It is zero after a cycle without `rd_en`, and zero after a read of an address outside the register.
- R3: With `TRIG_SRC = TRIG_SELF`, a read of word address `BASE_ADDR` (sub-word 0) does two things at that edge. It loads the whole buffer from `field_in`, and it returns `field_in[31:0]` as sampled at that edge, not the buffer.
- R4: A read of a sub-word that is not the self-trigger returns the buffer as it stood before that edge, never the live value. Sub-word 0 is the trigger only in self mode.
- R5: With `TRIG_SRC = TRIG_OTHER_REG`, a read of word address `TRIG_ADDR` loads the buffer, and this block returns zero for it. A read of `BASE_ADDR` then returns buffered bits [31:0].
- R6: With `TRIG_SRC = TRIG_EXT`, every edge at which `ext_trig` equals `EXT_ACT_HIGH` loads the buffer, and reads never load it. In the other modes `ext_trig` has no effect.
- R7: All `NUM_FIELDS` bits of `rd_strobe` are high, combinationally, in exactly the cycles whose closing edge loads the buffer. They are low in every other cycle, including cycles with buffered reads.
- R8: Sub-word k lives at word address `BASE_ADDR + k` and carries bits [32k+31:32k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| field_in | input | REG_W | Live field values from hardware |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rd_addr | input | ADDR_W | Word address of the read |
| ext_trig | input | 1 | External snapshot trigger, level set by EXT_ACT_HIGH |
| rd_data | output | ACC_W | Registered read data |
| rd_strobe | output | NUM_FIELDS | Per-field sample strobes |

## Verification
The bench runs three instances side by side: self, other-register and active-low external trigger. A shared random stream of reads and trigger levels drives all three, so any mix-up between modes shows at once.

The bench targets the following cases:
- **Self-trigger low-word read while the live value changes.** A design that returns the old buffer here hands software a torn 64-bit value.
- **High-word read after the live value has moved on.** A design that returns live data fails this check.
- **Buffered reads that coincide with a trigger.** These must show the pre-edge snapshot.
- **The external level in the non-external modes.** It must be ignored there.
- **Strobe placement.** A strobe fired on buffered reads, or one cycle late, is caught on every cycle.

// File: rtl/snap_pkg.sv
`timescale 1ns/1ps
package snap_pkg;
  typedef enum logic [1:0] {
    TRIG_SELF      = 2'd0,
    TRIG_OTHER_REG = 2'd1,
    TRIG_EXT       = 2'd2
  } trig_src_e;
endpackage

// File: rtl/snap_decode.sv
`timescale 1ns/1ps
module snap_decode #(
  parameter int                   ADDR_W       = 8,
  parameter int                   SUBW         = 2,
  parameter int                   SUBW_W       = 1,
  parameter logic [ADDR_W-1:0]    BASE_ADDR    = 'h10,
  parameter logic [ADDR_W-1:0]    TRIG_ADDR    = 'h20,
  parameter snap_pkg::trig_src_e  TRIG_SRC     = snap_pkg::TRIG_SELF,
  parameter bit                   EXT_ACT_HIGH = 1'b1
) (
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              ext_trig,
  output logic              hit,
  output logic [SUBW_W-1:0] idx,
  output logic              load
);
  logic [ADDR_W-1:0] off;

  always_comb begin
    off = rd_addr - BASE_ADDR;
    hit = rd_en && (rd_addr >= BASE_ADDR) && (off < ADDR_W'(SUBW));
    idx = off[SUBW_W-1:0];
  end

  always_comb begin
    case (TRIG_SRC)
      snap_pkg::TRIG_SELF:      load = rd_en && (rd_addr == BASE_ADDR);
      snap_pkg::TRIG_OTHER_REG: load = rd_en && (rd_addr == TRIG_ADDR);
      default:                  load = (ext_trig == EXT_ACT_HIGH);
    endcase
  end
endmodule

// File: rtl/snap_buffer.sv
`timescale 1ns/1ps
module snap_buffer #(
  parameter int REG_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [REG_W-1:0] live,
  output logic [REG_W-1:0] buf_q
);
  always_ff @(posedge clk) begin
    if (rst)       buf_q <= '0;
    else if (load) buf_q <= live;
  end

  // R3: a load edge captures the full live value
  p_capture_r3: assert property (@(posedge clk) disable iff (rst)
    load |=> (buf_q == $past(live)));
  // R4: without a load the snapshot stays put
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(buf_q));
endmodule

// File: rtl/snap_rdport.sv
`timescale 1ns/1ps
module snap_rdport #(
  parameter int REG_W      = 64,
  parameter int ACC_W      = 32,
  parameter int SUBW       = 2,
  parameter int SUBW_W     = 1,
  parameter bit BYPASS_LOW = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              hit,
  input  logic [SUBW_W-1:0] idx,
  input  logic [ACC_W-1:0]  live_low,
  input  logic [REG_W-1:0]  buf_flat,
  output logic [ACC_W-1:0]  rd_data
);
  logic [ACC_W-1:0] words [SUBW];

  for (genvar g = 0; g < SUBW; g++) begin : g_word
    assign words[g] = buf_flat[g*ACC_W +: ACC_W];
  end

  always_ff @(posedge clk) begin
    if (rst || !hit)                  rd_data <= '0;
    else if (BYPASS_LOW && idx == '0) rd_data <= live_low;
    else                              rd_data <= words[idx];
  end

  // R2: idle cycles leave zero on the read bus
  p_idle_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rd_data == '0));
endmodule

// File: rtl/snap_rdreg.sv
`timescale 1ns/1ps
module snap_rdreg #(
  parameter int                  REG_W        = 64,
  parameter int                  ACC_W        = 32,
  parameter int                  NUM_FIELDS   = 4,
  parameter int                  ADDR_W       = 8,
  parameter logic [ADDR_W-1:0]   BASE_ADDR    = 'h10,
  parameter logic [ADDR_W-1:0]   TRIG_ADDR    = 'h20,
  parameter snap_pkg::trig_src_e TRIG_SRC     = snap_pkg::TRIG_SELF,
  parameter bit                  EXT_ACT_HIGH = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [REG_W-1:0]      field_in,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     rd_addr,
  input  logic                  ext_trig,
  output logic [ACC_W-1:0]      rd_data,
  output logic [NUM_FIELDS-1:0] rd_strobe
);
  localparam int SUBW   = REG_W / ACC_W;
  localparam int SUBW_W = (SUBW > 1) ? $clog2(SUBW) : 1;
  localparam bit BYPASS = (TRIG_SRC == snap_pkg::TRIG_SELF);

  logic              hit_w, load_w;
  logic [SUBW_W-1:0] idx_w;
  logic [REG_W-1:0]  buf_w;

  snap_decode #(
    .ADDR_W(ADDR_W), .SUBW(SUBW), .SUBW_W(SUBW_W), .BASE_ADDR(BASE_ADDR),
    .TRIG_ADDR(TRIG_ADDR), .TRIG_SRC(TRIG_SRC), .EXT_ACT_HIGH(EXT_ACT_HIGH)
  ) u_decode (
    .rd_en(rd_en), .rd_addr(rd_addr), .ext_trig(ext_trig),
    .hit(hit_w), .idx(idx_w), .load(load_w)
  );

  snap_buffer #(.REG_W(REG_W)) u_buffer (
    .clk(clk), .rst(rst), .load(load_w), .live(field_in), .buf_q(buf_w)
  );

  snap_rdport #(
    .REG_W(REG_W), .ACC_W(ACC_W), .SUBW(SUBW), .SUBW_W(SUBW_W), .BYPASS_LOW(BYPASS)
  ) u_rdport (
    .clk(clk), .rst(rst), .rd_en(rd_en), .hit(hit_w), .idx(idx_w),
    .live_low(field_in[ACC_W-1:0]), .buf_flat(buf_w), .rd_data(rd_data)
  );

  assign rd_strobe = {NUM_FIELDS{load_w}};

  // R7: a strobe cycle is always followed by a fresh snapshot
  p_strobe_sample_r7: assert property (@(posedge clk) disable iff (rst)
    (|rd_strobe) |=> (buf_w == $past(field_in)));

  if (TRIG_SRC == snap_pkg::TRIG_SELF) begin : g_chk_self
    // R3: low sub-word bypasses the buffer
    p_bypass_r3: assert property (@(posedge clk) disable iff (rst)
      (rd_en && rd_addr == BASE_ADDR) |=> (rd_data == $past(field_in[ACC_W-1:0])));
  end else if (TRIG_SRC == snap_pkg::TRIG_OTHER_REG) begin : g_chk_other
    // R5: trigger address is not served here
    p_trig_addr_zero_r5: assert property (@(posedge clk) disable iff (rst)
      (rd_en && rd_addr == TRIG_ADDR) |=> (rd_data == '0));
  end else begin : g_chk_ext
    // R6: active external level raises every strobe
    p_ext_level_r6: assert property (@(posedge clk) disable iff (rst)
      (ext_trig == EXT_ACT_HIGH) |-> (&rd_strobe));
  end
endmodule

// File: tb/test_snap_rdreg.sv
`timescale 1ns/1ps
module test_snap_rdreg;
  localparam logic [7:0] BASE = 8'h10;
  localparam logic [7:0] TRIG = 8'h20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] field_in = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic        ext_trig = 1'b1;
  logic [31:0] rd_o [3];
  logic [3:0]  st_o [3];

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;
  logic [63:0] mbuf [3];
  logic [31:0] exp_rd [3];
  string rd_tag [3] = '{"R2 R3 R4 R8", "R2 R4 R5 R6", "R2 R4 R6"};

  always #10 clk = ~clk;

  snap_rdreg #(.TRIG_SRC(snap_pkg::TRIG_SELF)) i_snap_rdreg (
    .clk(clk), .rst(rst), .field_in(field_in), .rd_en(rd_en), .rd_addr(rd_addr),
    .ext_trig(ext_trig), .rd_data(rd_o[0]), .rd_strobe(st_o[0]));
  snap_rdreg #(.TRIG_SRC(snap_pkg::TRIG_OTHER_REG)) i_snap_rdreg_other (
    .clk(clk), .rst(rst), .field_in(field_in), .rd_en(rd_en), .rd_addr(rd_addr),
    .ext_trig(ext_trig), .rd_data(rd_o[1]), .rd_strobe(st_o[1]));
  snap_rdreg #(.TRIG_SRC(snap_pkg::TRIG_EXT), .EXT_ACT_HIGH(1'b0)) i_snap_rdreg_ext (
    .clk(clk), .rst(rst), .field_in(field_in), .rd_en(rd_en), .rd_addr(rd_addr),
    .ext_trig(ext_trig), .rd_data(rd_o[2]), .rd_strobe(st_o[2]));

  function automatic bit trig_of(int mode, logic en, logic [7:0] a, logic e);
    case (mode)
      0:       return en && (a == BASE);
      1:       return en && (a == TRIG);
      default: return (e == 1'b0);
    endcase
  endfunction

  function automatic logic [31:0] rd_of(int mode, logic [63:0] b, logic [63:0] live,
                                        logic en, logic [7:0] a);
    if (!en) return 32'd0;
    if (a == BASE) return (mode == 0) ? live[31:0] : b[31:0];
    if (a == BASE + 8'd1) return b[63:32];
    return 32'd0;
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(logic [63:0] f, logic en, logic [7:0] a, logic e);
    field_in = f; rd_en = en; rd_addr = a; ext_trig = e;
    #1;
    for (int m = 0; m < 3; m++) begin
      bit t = trig_of(m, en, a, e);
      check("R7", $sformatf("strobe inst%0d", m), {28'd0, st_o[m]}, t ? 32'hF : 32'h0);
      exp_rd[m] = rd_of(m, mbuf[m], f, en, a);
      if (t) mbuf[m] = f;
    end
    @(posedge clk);
    @(negedge clk);
    for (int m = 0; m < 3; m++)
      check(rd_tag[m], $sformatf("rd_data inst%0d addr=%h", m, a), rd_o[m], exp_rd[m]);
  endtask

  initial begin
    void'($urandom(32'd5150));
    for (int m = 0; m < 3; m++) mbuf[m] = '0;
    repeat (3) @(negedge clk);
    for (int m = 0; m < 3; m++) begin
      check("R1", "reset rd_data", rd_o[m], 32'd0);
      check("R1", "reset strobe", {28'd0, st_o[m]}, 32'd0);
    end
    rst = 1'b0;
    // directed corners
    step(64'hA1A2A3A4_B1B2B3B4, 1'b1, BASE + 8'd1, 1'b1); // R1 empty buffer
    step(64'h11112222_33334444, 1'b1, BASE, 1'b1);        // R3 self load
    step(64'h55556666_77778888, 1'b1, BASE + 8'd1, 1'b1); // R4 snapshot hi
    step(64'h9999AAAA_BBBBCCCC, 1'b1, TRIG, 1'b1);        // R5 other load
    step(64'hDDDDEEEE_FFFF0000, 1'b1, BASE, 1'b1);        // R5 buffered lo
    step(64'h0F0F0F0F_F0F0F0F0, 1'b0, 8'h00, 1'b0);       // R6 ext load
    step(64'h12345678_9ABCDEF0, 1'b1, BASE + 8'd1, 1'b1); // R6 buffered hi
    step(64'h12345678_9ABCDEF0, 1'b1, BASE + 8'd2, 1'b1); // R2 past end
    step(64'h12345678_9ABCDEF0, 1'b1, BASE - 8'd1, 1'b1); // R2 below base
    step(64'hCAFEF00D_DEADBEEF, 1'b1, BASE, 1'b0);        // R6 ext with read
    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] f = {$urandom(), $urandom()};
      logic [7:0]  a;
      case ($urandom % 5)
        0:       a = BASE;
        1:       a = BASE + 8'd1;
        2:       a = TRIG;
        default: a = 8'($urandom);
      endcase
      step(f, ($urandom % 4) != 0, a, ($urandom % 6) != 0);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R2 watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule